// File: doc/BRIEF.md
# Asynchronous Serial Port Controller

This block is a full-duplex asynchronous serial port with a small register file on a byte-wide bus. Software picks a frame format (seven or eight data bits, optional even or odd parity, one or two stop bits) and a bit rate. It can also pick an external 16x sample clock or ask for the internal bit clock on an output pin. It then enables the transmitter and the receiver on their own. The transmitter sends from a one-byte holding register. The receiver places each complete frame into a receive data register and raises flags for a full buffer, a bad parity, a missing stop bit and a lost frame.

Enable bits gate the serial pins. While the transmitter is off, its output enable is low. While the receiver is off, the line input is replaced by an idle level. Turning the transmitter off marks the holding register empty. Turning the receiver off leaves every receive flag and the received byte as they were. The bit-clock output starts as soon as the clock-select field asks for it, whatever the enables are. A settled bit in the status register tells software when one bit interval has passed since the last clock or format change. Three interrupt requests are formed from the flags and their enables.

Register map (bus_addr): 0 control, 1 format, 2 bit rate, 3 transmit data (write), 4 receive data (read), 5 status.

Top module: `aser_core`

## Requirements
- R1: After reset the control, format and rate registers read 0, status reads 0x21 (bit 0 transmit-empty, bit 5 transmit-end), `txd_oe` and `clk_oe` are 0 and all interrupt requests are 0.
- R2: With the internal clock (control bits 7:6 = 00 or 01), every serial bit on `txd_o` lasts 64*(N+1) system clocks, where N is the rate register value. The byte 0x00 in 8N1 format keeps `txd_o` low for exactly 9 bit times.
- R3: With control bit 7 = 1, each bit lasts 16 rising edges of `ext_clk_i` and the rate register has no effect.
- R4: With control bits 7:6 = 01, `clk_oe` is 1 and `clk_o` runs with a period of one bit time immediately, even while control bits 0 (transmit enable) and 1 (receive enable) are 0.
- R5: A frame is a 0 start bit, the data LSB first (7 bits when format bit 0 = 1, else 8), then a parity bit when format bit 1 = 1 (odd when format bit 2 = 1, else even), then 1 stop bit, or 2 when format bit 3 = 1. The receiver returns the sent byte, masked to the data length.
- R6: `txd_oe` equals control bit 0. While control bit 1 is 0, frames on `rxd_i` set no receive flag.
- R7: A control write with bit 0 = 0 sets status bit 0. A write to the transmit data register clears it.
- R8: Clearing control bit 1 leaves status bits 4:1 and the receive data register unchanged.
- R9: A format write made while control bit 0 or bit 1 is 1 is ignored. While both are 0 it takes effect.
- R10: Status bit 2 (parity error) is set on a parity mismatch and status bit 3 (framing error) when the stop bit samples 0, together with status bit 1 (receive full).
- R11: A frame that completes while status bit 1 is 1 sets status bit 4 (overrun), and the receive data register keeps its old byte.
- R12: Status bits 4:1 clear only when 0 is written to them after a status read returned them as 1. Writing 0 without a prior read leaves them set.
- R13: Status bit 6 reads 0 right after a write to the rate register, to the format register, or to control bits 7:6, and reads 1 once 16 sample ticks (one bit time) have passed.
- R14: `irq_rx` = receive-full AND control bit 2. `irq_tx` = transmit-empty AND control bit 3. `irq_tend` = transmit-empty AND transmitter idle AND control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| txd_o | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Transmit pin drive enable |
| rxd_i | input | 1 | Serial receive line |
| ext_clk_i | input | 1 | External 16x sample clock |
| clk_o | output | 1 | Bit clock output |
| clk_oe | output | 1 | Bit clock drive enable |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_tend | output | 1 | Transmit-end interrupt request |

## Verification
The main path is driven by looping the transmit line back into the receiver. The bench sweeps 32 spread byte values in each of three formats: 8 bits with no parity and one stop bit, 7 bits with even parity, and 8 bits with odd parity and two stop bits. This separates errors in bit order, in length masking, in the parity sense and in stop handling. The bit timing is measured on the line as the length of a zero byte at two rate values and under an external clock, which tells apart a divider that ignores the rate from one that wrongly uses it. The bench also builds its own frames with a bad parity bit, a zero stop bit, two frames back to back, and a frame sent while the receiver is disabled. These cases separate the framing, parity, overrun and gating paths.

// File: rtl/aser_pkg.sv
// Shared types and register indices of the asynchronous serial port.
package aser_pkg;
    localparam int DW = 8;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_FMT  = 3'd1;
    localparam logic [2:0] A_RATE = 3'd2;
    localparam logic [2:0] A_TXD  = 3'd3;
    localparam logic [2:0] A_RXD  = 3'd4;
    localparam logic [2:0] A_STAT = 3'd5;

    localparam int C_TXEN = 0;
    localparam int C_RXEN = 1;
    localparam int C_RIE  = 2;
    localparam int C_TIE  = 3;
    localparam int C_TEIE = 4;

    // Format register layout, bit 0 first: seven, par_en, par_odd, two_stop.
    typedef struct packed {
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic seven;
    } fmt_t;

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ser_st_t;
endpackage

// File: rtl/aser_baud.sv
// Sample-tick generator: one tick per PRE*(rate+1) clocks, or one per
// rising edge of the external clock. Also forms the bit clock (16 ticks).
// Assumes PRE >= 2 and an external clock slower than clk/2.
module aser_baud #(
    parameter int RATE_W = 8,
    parameter int PRE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              ext_sel,
    input  logic              ext_clk,
    output logic              tick,
    output logic              bclk
);
    localparam int CNT_W = RATE_W + $clog2(PRE) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [2:0]       es;
    logic [3:0]       ph;

    assign lim  = CNT_W'(PRE) * (CNT_W'(rate) + CNT_W'(1)) - CNT_W'(1);
    assign bclk = ph[3];

    // Free-running divider, wraps early if the rate shrinks.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                 cnt <= cnt + CNT_W'(1);
    end

    // Synchronise the external clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) es <= '0;
        else        es <= {es[1:0], ext_clk};
    end

    // Select the tick source.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ext_sel ? (es[1] & ~es[2]) : (cnt >= lim);
    end

    // Bit clock phase: 16 ticks per period.
    always_ff @(posedge clk) begin
        if (!rst_n)    ph <= '0;
        else if (tick) ph <= ph + 4'd1;
    end

    assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/aser_tx.sv
// Frame transmitter. Loads a byte only on a sample tick, so every bit spans
// exactly 16 ticks. Returns to idle at once when disabled.
module aser_tx import aser_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  fmt_t          fmt,
    input  logic          have,
    input  logic [DW-1:0] data,
    output logic          take,
    output logic          busy,
    output logic          txd
);
    ser_st_t       st;
    logic [3:0]    sub;
    logic [2:0]    bitn;
    logic [DW-1:0] sh;
    logic          pbit;
    logic          stop2;
    logic [2:0]    last;
    logic [DW-1:0] dmask;

    assign last  = fmt.seven ? 3'd6 : 3'd7;
    assign dmask = fmt.seven ? {1'b0, data[6:0]} : data;
    assign take  = en && tick && (st == S_IDLE) && have;
    assign busy  = (st != S_IDLE);

    // Frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; sub <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0; stop2 <= 1'b0;
        end else if (!en) begin
            st <= S_IDLE;
        end else if (tick) begin
            if (st == S_IDLE) begin
                if (have) begin
                    sh <= dmask; pbit <= (^dmask) ^ fmt.par_odd;
                    st <= S_START; sub <= '0; stop2 <= 1'b0;
                end
            end else begin
                sub <= sub + 4'd1;
                if (sub == 4'd15) begin
                    case (st)
                        S_START: begin st <= S_DATA; bitn <= '0; end
                        S_DATA: begin
                            sh <= sh >> 1; bitn <= bitn + 3'd1;
                            if (bitn == last) st <= fmt.par_en ? S_PAR : S_STOP;
                        end
                        S_PAR: st <= S_STOP;
                        S_STOP: begin
                            if (fmt.two_stop && !stop2) stop2 <= 1'b1;
                            else                        st <= S_IDLE;
                        end
                        default: st <= S_IDLE;
                    endcase
                end
            end
        end
    end

    // Line level from the state.
    always_comb begin
        case (st)
            S_START: txd = 1'b0;
            S_DATA:  txd = sh[0];
            S_PAR:   txd = pbit;
            default: txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/aser_rx.sv
// Frame receiver. Finds the start edge on the 16x tick, re-checks it at
// mid-bit and samples each later bit 16 ticks apart. Checks the first stop bit only.
module aser_rx import aser_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          rxd,
    input  logic          seven,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    ser_st_t       st;
    logic [1:0]    sy;
    logic          line;
    logic [3:0]    sub;
    logic [2:0]    bitn;
    logic [DW-1:0] sh;
    logic          pbit;
    logic [2:0]    last;

    assign line = sy[1];
    assign last = seven ? 3'd6 : 3'd7;
    assign data = seven ? {1'b0, sh[7:1]} : sh;

    // Two-flop synchroniser, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) sy <= 2'b11;
        else        sy <= {sy[0], rxd};
    end

    // Sampling sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; sub <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0;
            done <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
        end else if (!en) begin
            st <= S_IDLE; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                sub <= sub + 4'd1;
                case (st)
                    S_IDLE: if (!line) begin st <= S_START; sub <= '0; end
                    S_START: if (sub == 4'd7) begin
                        sub <= '0; bitn <= '0;
                        st  <= line ? S_IDLE : S_DATA;
                    end
                    S_DATA: if (sub == 4'd15) begin
                        sh <= {line, sh[7:1]}; bitn <= bitn + 3'd1;
                        if (bitn == last) st <= par_en ? S_PAR : S_STOP;
                    end
                    S_PAR: if (sub == 4'd15) begin pbit <= line; st <= S_STOP; end
                    S_STOP: if (sub == 4'd15) begin
                        done <= 1'b1;
                        ferr <= !line;
                        perr <= par_en && (pbit != ((^data) ^ par_odd));
                        st   <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/aser_core.sv
// Asynchronous serial port top: register file, flags, pin gating and
// interrupt requests around the tick generator, transmitter and receiver.
// Assumes one-cycle bus strobes and RATE_W <= 8.
module aser_core import aser_pkg::*; #(
    parameter int RATE_W = 8,
    parameter int PRE    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          txd_o,
    output logic          txd_oe,
    input  logic          rxd_i,
    input  logic          ext_clk_i,
    output logic          clk_o,
    output logic          clk_oe,
    output logic          irq_rx,
    output logic          irq_tx,
    output logic          irq_tend
);
    localparam int SET_W = 5;

    logic [DW-1:0]     ctrl;
    fmt_t              fmt;
    logic [RATE_W-1:0] rate;
    logic [DW-1:0]     tdr;
    logic [DW-1:0]     rdr;
    logic              tx_empty;
    logic [3:0]        rflag;      // {overrun, framing, parity, full}
    logic [3:0]        seen;
    logic [SET_W-1:0]  settle;
    logic              tick, bclk, take, tx_busy, txd_raw;
    logic              rx_done, rx_perr, rx_ferr;
    logic [DW-1:0]     rx_data;
    logic              wr_ctrl, wr_fmt, wr_rate, wr_txd, wr_stat, rd_stat;
    logic              fmt_open, cfg_wr, settled;
    logic [DW-1:0]     stat;

    assign wr_ctrl  = bus_sel &  bus_wr & (bus_addr == A_CTRL);
    assign wr_fmt   = bus_sel &  bus_wr & (bus_addr == A_FMT);
    assign wr_rate  = bus_sel &  bus_wr & (bus_addr == A_RATE);
    assign wr_txd   = bus_sel &  bus_wr & (bus_addr == A_TXD);
    assign wr_stat  = bus_sel &  bus_wr & (bus_addr == A_STAT);
    assign rd_stat  = bus_sel & ~bus_wr & (bus_addr == A_STAT);
    assign fmt_open = !ctrl[C_TXEN] && !ctrl[C_RXEN];
    assign cfg_wr   = wr_rate | (wr_fmt & fmt_open) | (wr_ctrl & (bus_wdata[7:6] != ctrl[7:6]));
    assign settled  = settle[SET_W-1];
    assign stat     = {1'b0, settled, tx_empty & !tx_busy, rflag, tx_empty};

    aser_baud #(.RATE_W(RATE_W), .PRE(PRE)) u_baud (
        .clk(clk), .rst_n(rst_n), .rate(rate), .ext_sel(ctrl[7]),
        .ext_clk(ext_clk_i), .tick(tick), .bclk(bclk));

    aser_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(ctrl[C_TXEN]), .tick(tick), .fmt(fmt),
        .have(!tx_empty), .data(tdr), .take(take), .busy(tx_busy), .txd(txd_raw));

    aser_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(ctrl[C_RXEN]), .tick(tick),
        .rxd(ctrl[C_RXEN] ? rxd_i : 1'b1), .seven(fmt.seven), .par_en(fmt.par_en),
        .par_odd(fmt.par_odd), .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr));

    // Configuration registers; format is locked while either side is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0; fmt <= '0; rate <= '0; tdr <= '0;
        end else begin
            if (wr_ctrl)             ctrl <= bus_wdata;
            if (wr_fmt && fmt_open)  fmt  <= fmt_t'(bus_wdata[3:0]);
            if (wr_rate)             rate <= bus_wdata[RATE_W-1:0];
            if (wr_txd)              tdr  <= bus_wdata;
        end
    end

    // Transmit-empty flag: set on disable or hand-off, cleared by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                tx_empty <= 1'b1;
        else if (wr_ctrl && !bus_wdata[C_TXEN])   tx_empty <= 1'b1;
        else if (wr_txd)                           tx_empty <= 1'b0;
        else if (take)                             tx_empty <= 1'b1;
    end

    // Receive flags with read-then-write-zero clearing; new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rflag <= '0; seen <= '0; rdr <= '0;
        end else begin
            if (rd_stat) seen <= seen | rflag;
            if (wr_stat) begin
                for (int i = 0; i < 4; i++) begin
                    if (!bus_wdata[i+1] && seen[i]) begin
                        rflag[i] <= 1'b0;
                        seen[i]  <= 1'b0;
                    end
                end
            end
            if (rx_done && ctrl[C_RXEN]) begin
                if (rflag[0]) begin
                    rflag[3] <= 1'b1;
                end else begin
                    rdr      <= rx_data;
                    rflag[0] <= 1'b1;
                    if (rx_perr) rflag[1] <= 1'b1;
                    if (rx_ferr) rflag[2] <= 1'b1;
                end
            end
        end
    end

    // One-bit-interval settle counter after any clock or format change.
    always_ff @(posedge clk) begin
        if (!rst_n)                 settle <= '0;
        else if (cfg_wr)            settle <= '0;
        else if (tick && !settled)  settle <= settle + SET_W'(1);
    end

    // Register read mux.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl;
            A_FMT:   bus_rdata = {4'b0, fmt};
            A_RATE:  bus_rdata = DW'(rate);
            A_TXD:   bus_rdata = tdr;
            A_RXD:   bus_rdata = rdr;
            A_STAT:  bus_rdata = stat;
            default: bus_rdata = '0;
        endcase
    end

    assign txd_o    = txd_raw;
    assign txd_oe   = ctrl[C_TXEN];
    assign clk_oe   = (ctrl[7:6] == 2'b01);
    assign clk_o    = clk_oe & bclk;
    assign irq_rx   = rflag[0] & ctrl[C_RIE];
    assign irq_tx   = tx_empty & ctrl[C_TIE];
    assign irq_tend = tx_empty & !tx_busy & ctrl[C_TEIE];

    assert_txe_on_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[C_TXEN]) |=> tx_empty);
    assert_rdr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[C_RXEN] |=> ($stable(rdr) && !$rose(rflag[3])));
    assert_fmt_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[C_TXEN] || ctrl[C_RXEN]) |=> $stable(fmt));
    assert_overrun_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rflag[3]) |-> $stable(rdr));
endmodule

// File: tb/aser_core_test.sv
`timescale 1ns/1ps
module aser_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       txd_o, txd_oe, rxd_i, clk_o, clk_oe, irq_rx, irq_tx, irq_tend;
    logic       ext_clk = 1'b0, ext_run = 1'b0;
    logic       loop = 1'b0, drv = 1'b1, fin = 1'b0;
    int         n_cmp = 0, n_bad = 0;

    localparam int BIT0 = 64;   // bit time with PRE=4, rate 0

    always #2 clk = ~clk;
    always begin
        #16;
        ext_clk = ext_run ? ~ext_clk : 1'b0;
    end

    assign rxd_i = loop ? (txd_oe ? txd_o : 1'b1) : drv;

    aser_core uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd_o(txd_o), .txd_oe(txd_oe),
        .rxd_i(rxd_i), .ext_clk_i(ext_clk), .clk_o(clk_o), .clk_oe(clk_oe),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_tend(irq_tend));

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 1'b0;
    endtask

    task automatic wait_stat(input int b, input logic lvl);
        logic [7:0] s;
        for (int g = 0; g < 4000; g++) begin
            rd(3'd5, s);
            if (s[b] === lvl) return;
        end
    endtask

    task automatic low_len(output int n);
        int g = 0;
        while (txd_o !== 1'b0 && g < 20000) begin @(negedge clk); g++; end
        n = 0;
        while (txd_o === 1'b0 && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic clk_period(output int n);
        int g = 0;
        while (clk_o !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (clk_o !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
        n = 0;
        while (clk_o === 1'b1 && n < 5000) begin @(negedge clk); n++; end
        while (clk_o === 1'b0 && n < 5000) begin @(negedge clk); n++; end
    endtask

    // Drive one frame on rxd_i with rate 0 timing.
    task automatic send(input logic [7:0] d, input int nb, input logic usep,
                        input logic pb, input logic stopv);
        drv = 1'b0; repeat (BIT0) @(negedge clk);
        for (int i = 0; i < nb; i++) begin drv = d[i]; repeat (BIT0) @(negedge clk); end
        if (usep) begin drv = pb; repeat (BIT0) @(negedge clk); end
        drv = stopv; repeat (stopv ? BIT0 : 48) @(negedge clk);
        drv = 1'b1; repeat (BIT0 * 2) @(negedge clk);
    endtask

    task automatic clear_flags();
        logic [7:0] s;
        rd(3'd5, s); wr(3'd5, 8'h00);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!fin) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, d;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd5, s); chk("R1 status", s, 8'h21);
        rd(3'd0, s); chk("R1 ctrl", s, 0);
        chk("R1 pins", {txd_oe, clk_oe, irq_rx, irq_tx, irq_tend}, 0);

        // R4 clock output with both enables off
        wr(3'd0, 8'h40);
        chk("R4 clk_oe", clk_oe, 1);
        clk_period(n); chk("R4 period rate0", n, BIT0);
        wr(3'd2, 8'd2);
        clk_period(n); clk_period(n); chk("R4 period rate2", n, 3 * BIT0);

        // R13 settle status
        wr(3'd2, 8'd0);
        rd(3'd5, s); chk("R13 just written", s[6], 0);
        repeat (80) @(negedge clk);
        rd(3'd5, s); chk("R13 after one bit", s[6], 1);

        // R9 format lock
        wr(3'd0, 8'h01); wr(3'd1, 8'h0F);
        rd(3'd1, s); chk("R9 locked", s, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h0F);
        rd(3'd1, s); chk("R9 open", s, 8'h0F);
        wr(3'd1, 8'h00);

        // R6 transmit pin gating
        chk("R6 txd_oe off", txd_oe, 0);
        wr(3'd0, 8'h01); chk("R6 txd_oe on", txd_oe, 1);

        // R2 bit time at two rates
        wr(3'd3, 8'h00); low_len(n); chk("R2 zero byte rate0", n, 9 * BIT0);
        wait_stat(5, 1'b1);
        wr(3'd2, 8'd2);
        wr(3'd3, 8'h00); low_len(n); chk("R2 zero byte rate2", n, 27 * BIT0);
        wait_stat(5, 1'b1);

        // R3 external clock, rate ignored
        ext_run = 1'b1;
        wr(3'd2, 8'd5); wr(3'd0, 8'h81);
        wr(3'd3, 8'h00); low_len(n); chk("R3 ext zero byte", n, 9 * 16 * 8);
        wait_stat(5, 1'b1);
        ext_run = 1'b0;
        wr(3'd0, 8'h00); wr(3'd2, 8'd0);

        // R5 loopback sweep over three formats
        loop = 1'b1;
        for (int f = 0; f < 3; f++) begin
            logic [7:0] fv, mk;
            fv = (f == 0) ? 8'h00 : (f == 1) ? 8'h03 : 8'h0E;
            mk = (f == 1) ? 8'h7F : 8'hFF;
            wr(3'd0, 8'h00); wr(3'd1, fv); clear_flags(); wr(3'd0, 8'h03);
            for (int v = 0; v < 32; v++) begin
                logic [7:0] b;
                b = 8'((v * 37 + 5) ^ (v << 3));
                wr(3'd3, b);
                wait_stat(1, 1'b1);
                rd(3'd4, d); chk("R5 loopback data", d, b & mk);
                rd(3'd5, s); chk("R5 R10 no errors", s[4:2], 0);
                wr(3'd5, 8'h00);
            end
            wait_stat(5, 1'b1);
        end
        loop = 1'b0;

        // R10 parity error (8E1, wrong parity bit)
        wr(3'd0, 8'h00); wr(3'd1, 8'h02); clear_flags(); wr(3'd0, 8'h02);
        send(8'h35, 8, 1'b1, 1'b1, 1'b1);
        rd(3'd5, s); chk("R10 parity flags", s[4:1], 4'b0011);
        clear_flags();
        // R10 framing error (8N1, stop 0)
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h02);
        send(8'hC4, 8, 1'b0, 1'b0, 1'b0);
        rd(3'd5, s); chk("R10 framing flags", s[4:1], 4'b0101);
        rd(3'd4, d); chk("R10 framing data", d, 8'hC4);
        clear_flags();

        // R11 overrun
        send(8'h55, 8, 1'b0, 1'b0, 1'b1);
        send(8'hAA, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd5, s); chk("R11 overrun flags", s[4:1], 4'b1001);
        rd(3'd4, d); chk("R11 data kept", d, 8'h55);

        // R8 receive disable keeps flags and data
        wr(3'd0, 8'h00);
        rd(3'd5, s); chk("R8 flags kept", s[4:1], 4'b1001);
        rd(3'd4, d); chk("R8 data kept", d, 8'h55);

        // R6 receive gating
        wr(3'd5, 8'h00);
        send(8'h33, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd5, s); chk("R6 rx gated", s[4:1], 0);
        rd(3'd4, d); chk("R6 rx gated data", d, 8'h55);

        // R12 clear needs a prior read
        wr(3'd0, 8'h02);
        send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
        wr(3'd5, 8'h00);
        rd(3'd5, s); chk("R12 unread stays", s[1], 1);
        wr(3'd5, 8'h00);
        rd(3'd5, s); chk("R12 read then clear", s[1], 0);
        wr(3'd5, 8'h00);

        // R14 interrupts
        wr(3'd0, 8'h06);
        send(8'h71, 8, 1'b0, 1'b0, 1'b1);
        chk("R14 irq_rx", irq_rx, 1);
        wr(3'd0, 8'h18);
        chk("R14 irq_tx and irq_tend", {irq_tx, irq_tend}, 2'b11);
        wr(3'd3, 8'h12);
        chk("R14 irqs after data write", {irq_tx, irq_tend}, 2'b00);
        rd(3'd5, s); chk("R7 data write clears empty", s[0], 0);
        wr(3'd0, 8'h00);
        rd(3'd5, s); chk("R7 disable sets empty", s[0], 1);

        fin = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule